// File: doc/BRIEF.md
# Down-Counting Timer Channel with Pin Capture

This block is one 32-bit timer channel that runs on the peripheral clock and counts down. While the channel is running it takes count events from one of two sources. The first is an internal count-enable input, with one decrement for each cycle in which that input is high. The second is one external timer pin, whose rising edges, falling edges or both edges are counted after a two-flop synchroniser. When the counter is at zero and receives one more event, it loads itself from a reload register and sets a sticky underflow flag. That flag can drive an interrupt.

The same pin can serve as a capture trigger instead. While the channel runs from the internal source and capture is enabled, a chosen edge of the pin copies the live count into a capture register. It also sets a sticky capture flag, and it can raise a capture interrupt. Software uses a single-cycle write port and a combinational read port to load the count and the reload value, set up the channel and clear the flags.

The run controller is a three-state machine:
- **ST_HALT** (stopped): the start bit is 0, and counting and capture are both frozen.
- **ST_RUN_INT** (running on the internal enable): capture is allowed in this state only.
- **ST_RUN_EXT** (running on pin edges).

Its transitions are:
- **go_int**: from ST_HALT to ST_RUN_INT, when start is 1 and the source bit selects internal.
- **go_ext**: from ST_HALT to ST_RUN_EXT, when start is 1 and the source bit selects the pin.
- **to_ext**: from ST_RUN_INT to ST_RUN_EXT, and **to_int** for the reverse, when the source bit changes while running.
- **stop**: from either run state to ST_HALT, when start is 0.

The state follows the control register one cycle after a write.

Top module: `dct_timer_top`

## Requirements
- R1: After reset the control word (address 0) reads 0, reload (address 1) and count (address 2) read 32'hFFFF_FFFF, capture (address 3) reads 0, and both interrupt outputs are low.
- R2: Control bit 0 is start and bit 1 is source (0 = internal). With start=1 and source=0, every cycle with `tick_en` high decrements the count by one, and pin edges do not change the count.
- R3: With start=1 and source=1, control bits [3:2] select the counted pin edge (00 rising, 01 falling, 10 or 11 both). Each selected edge decrements the count by exactly one, and the change is visible three clock edges after the pin changes. `tick_en` is ignored in this mode.
- R4: An event that arrives with count 0 loads the reload value and sets the underflow flag (control bit 8). `irq_underflow` equals that flag ANDed with the underflow interrupt enable (control bit 6).
- R5: Control bits 8 (underflow flag) and 9 (capture flag) are cleared by writing 0 to them and are left unchanged by writing 1.
- R6: With start=0, neither `tick_en` nor pin edges change the count or the capture register.
- R7: Capture mode is control bits [5:4] (00 off, 01 capture only, 10 or 11 capture with interrupt). In ST_RUN_INT with capture on, a pin edge copies the count into the capture register and sets the capture flag. The edge is falling when bits [3:2] are 01 and rising otherwise. `irq_capture` is the capture flag ANDed with capture-mode bit 5.
- R8: No capture happens while `standby` is high or while the source is the pin.
- R9: A write to the count register takes priority over a count event in the same cycle. A write to the reload register leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 reload, 2 count, 3 capture) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| tick_en | input | 1 | Internal count enable |
| tmr_pin | input | 1 | External timer pin, asynchronous |
| standby | input | 1 | Standby request; blocks capture |
| irq_underflow | output | 1 | Underflow interrupt |
| irq_capture | output | 1 | Capture interrupt |

## Verification
The case that is hardest to reach from the ports is a capture on the pin while the counter is running from the internal source. The pin edge needs three clock edges to reach the capture register, and counting may move the value during that time. The stimulus brings the counter to a known value with explicit `tick_en` pulses and then keeps `tick_en` low while the pin edge travels through the synchroniser, so the value captured is exactly the known count. The same edge is then repeated under `standby` and in pin-source mode to show that no capture occurs. Randomised phases run the internal and external sources with a small reload value so that underflow wraps happen many times, and compare the count with a bench model after the run.

// File: rtl/dct_pkg.sv
package dct_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;

    typedef enum logic [1:0] {
        ST_HALT    = 2'd0,
        ST_RUN_INT = 2'd1,
        ST_RUN_EXT = 2'd2
    } run_state_e;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 2'd0,
        A_RELOAD = 2'd1,
        A_COUNT  = 2'd2,
        A_CAPT   = 2'd3
    } reg_addr_e;

    localparam int B_START = 0;
    localparam int B_SRC   = 1;
    localparam int B_EDGE  = 2;
    localparam int B_CAPM  = 4;
    localparam int B_UIE   = 6;
    localparam int B_UFLG  = 8;
    localparam int B_CFLG  = 9;
endpackage

// File: rtl/dct_pin_edge.sv
module dct_pin_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;
    assign fall = ~sync_q[SYNC_STAGES-1] & prev_q;

    // R3: a rising strobe reflects a high pin sampled SYNC_STAGES edges ago
    assert_rise_from_pin_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> $past(pin, SYNC_STAGES));
    // R3: strobes last one cycle
    assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rise || fall) |=> !(rise || fall));
endmodule

// File: rtl/dct_counter.sv
module dct_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         evt,
    input  logic         wr_count,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] reload,
    output logic [W-1:0] count,
    output logic         underflow
);
    logic [W-1:0] count_q;
    logic         at_zero;

    assign at_zero   = (count_q == '0);
    assign underflow = evt & at_zero & ~wr_count;
    assign count     = count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '1;
        end else if (wr_count) begin
            count_q <= wr_data;
        end else if (evt) begin
            count_q <= at_zero ? reload : count_q - 1'b1;
        end
    end

    assert_dec_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !wr_count && count_q != '0) |=> count_q == $past(count_q) - 1'b1);
    assert_reload_on_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !wr_count && count_q == '0) |=> count_q == $past(reload));
    assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_count |=> count_q == $past(wr_data));
    assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt && !wr_count) |=> $stable(count_q));
endmodule

// File: rtl/dct_capture.sv
module dct_capture #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fire,
    input  logic [W-1:0] count,
    output logic [W-1:0] capt
);
    logic [W-1:0] capt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) capt_q <= '0;
        else if (fire) capt_q <= count;
    end

    assign capt = capt_q;

    assert_capt_copies_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> capt_q == $past(count));
    assert_capt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(capt_q));
endmodule

// File: rtl/dct_timer_top.sv
module dct_timer_top
    import dct_pkg::*;
#(
    parameter int W           = DATA_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [W-1:0]      reg_wdata,
    output logic [W-1:0]      reg_rdata,
    input  logic              tick_en,
    input  logic              tmr_pin,
    input  logic              standby,
    output logic              irq_underflow,
    output logic              irq_capture
);
    run_state_e state_q, state_d;

    logic       start_q, src_q, uie_q, uflg_q, cflg_q;
    logic [1:0] edge_q, capm_q;
    logic [W-1:0] reload_q;

    logic wr_ctrl, wr_reload, wr_count;
    logic pin_rise, pin_fall;
    logic ext_evt, cap_edge;
    logic cnt_evt, cap_fire;
    logic uflow;
    logic [W-1:0] count_w, capt_w;

    assign wr_ctrl   = reg_wr && (reg_addr == A_CTRL);
    assign wr_reload = reg_wr && (reg_addr == A_RELOAD);
    assign wr_count  = reg_wr && (reg_addr == A_COUNT);

    // Control and reload registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q  <= 1'b0;
            src_q    <= 1'b0;
            edge_q   <= 2'b00;
            capm_q   <= 2'b00;
            uie_q    <= 1'b0;
            reload_q <= '1;
        end else begin
            if (wr_ctrl) begin
                start_q <= reg_wdata[B_START];
                src_q   <= reg_wdata[B_SRC];
                edge_q  <= reg_wdata[B_EDGE +: 2];
                capm_q  <= reg_wdata[B_CAPM +: 2];
                uie_q   <= reg_wdata[B_UIE];
            end
            if (wr_reload) reload_q <= reg_wdata;
        end
    end

    // Sticky flags: set wins, write 0 clears
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            uflg_q <= 1'b0;
            cflg_q <= 1'b0;
        end else begin
            if (uflow) uflg_q <= 1'b1;
            else if (wr_ctrl && !reg_wdata[B_UFLG]) uflg_q <= 1'b0;
            if (cap_fire) cflg_q <= 1'b1;
            else if (wr_ctrl && !reg_wdata[B_CFLG]) cflg_q <= 1'b0;
        end
    end

    // Run state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: begin
                if (start_q) state_d = src_q ? ST_RUN_EXT : ST_RUN_INT;  // go_ext / go_int
            end
            ST_RUN_INT: begin
                if (!start_q)   state_d = ST_HALT;                      // stop
                else if (src_q) state_d = ST_RUN_EXT;                   // to_ext
            end
            ST_RUN_EXT: begin
                if (!start_q)    state_d = ST_HALT;                     // stop
                else if (!src_q) state_d = ST_RUN_INT;                  // to_int
            end
            default: state_d = ST_HALT;
        endcase
    end

    // Edge qualification
    always_comb begin
        unique case (edge_q)
            2'b00:   ext_evt = pin_rise;
            2'b01:   ext_evt = pin_fall;
            default: ext_evt = pin_rise | pin_fall;
        endcase
        cap_edge = (edge_q == 2'b01) ? pin_fall : pin_rise;
    end

    // State outputs
    always_comb begin
        cnt_evt  = 1'b0;
        cap_fire = 1'b0;
        unique case (state_q)
            ST_HALT: begin
                cnt_evt  = 1'b0;
                cap_fire = 1'b0;
            end
            ST_RUN_INT: begin
                cnt_evt  = tick_en;
                cap_fire = cap_edge && (capm_q != 2'b00) && !standby;
            end
            ST_RUN_EXT: begin
                cnt_evt  = ext_evt;
                cap_fire = 1'b0;
            end
            default: begin
                cnt_evt  = 1'b0;
                cap_fire = 1'b0;
            end
        endcase
    end

    dct_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (tmr_pin),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    dct_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (cnt_evt),
        .wr_count (wr_count),
        .wr_data  (reg_wdata),
        .reload   (reload_q),
        .count    (count_w),
        .underflow(uflow)
    );

    dct_capture #(.W(W)) u_cap (
        .clk  (clk),
        .rst_n(rst_n),
        .fire (cap_fire),
        .count(count_w),
        .capt (capt_w)
    );

    // Read mux
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL: begin
                reg_rdata[B_START]    = start_q;
                reg_rdata[B_SRC]      = src_q;
                reg_rdata[B_EDGE +: 2] = edge_q;
                reg_rdata[B_CAPM +: 2] = capm_q;
                reg_rdata[B_UIE]      = uie_q;
                reg_rdata[B_UFLG]     = uflg_q;
                reg_rdata[B_CFLG]     = cflg_q;
            end
            A_RELOAD: reg_rdata = reload_q;
            A_COUNT:  reg_rdata = count_w;
            A_CAPT:   reg_rdata = capt_w;
            default:  reg_rdata = '0;
        endcase
    end

    assign irq_underflow = uflg_q & uie_q;
    assign irq_capture   = cflg_q & capm_q[1];

    assert_uflow_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        uflow |=> uflg_q);
    assert_capture_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fire |=> cflg_q);
    assert_halt_freezes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !wr_count) |=> ($stable(count_w) && $stable(capt_w)));
    assert_standby_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> $stable(capt_w));
    assert_ext_no_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN_EXT) |=> $stable(capt_w));
endmodule

// File: tb/dct_timer_top_test.sv
`timescale 1ns/1ps
module dct_timer_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tick_en = 1'b0;
    logic        tmr_pin = 1'b0;
    logic        standby = 1'b0;
    logic        irq_underflow, irq_capture;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [31:0] rd, exp_cnt, exp_rel;
    logic        exp_uf;

    always #5 clk = ~clk;

    dct_timer_top uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_en(tick_en),
        .tmr_pin(tmr_pin), .standby(standby),
        .irq_underflow(irq_underflow), .irq_capture(irq_capture)
    );

    function automatic logic [31:0] f_dec(input logic [31:0] c, input logic [31:0] r);
        return (c == 0) ? r : c - 1;
    endfunction

    function automatic bit f_counts(input logic o, input logic n, input logic [1:0] sel);
        if (o == n) return 0;
        if (sel == 2'b00) return n;
        if (sel == 2'b01) return !n;
        return 1;
    endfunction

    // flag bits written as 1 so they are kept
    function automatic logic [31:0] mk_ctrl(input logic st, input logic src,
                                           input logic [1:0] ed, input logic [1:0] cm,
                                           input logic uie);
        logic [31:0] v;
        v = '0;
        v[0] = st; v[1] = src; v[3:2] = ed; v[5:4] = cm; v[6] = uie;
        v[8] = 1'b1; v[9] = 1'b1;
        return v;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic rdreg(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(negedge clk);
        end
        tick_en = 1'b0;
    endtask

    task automatic set_pin(input logic v);
        tmr_pin = v;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rdreg(0, rd); chk("R1 ctrl", rd, 32'h0);
        rdreg(1, rd); chk("R1 reload", rd, 32'hFFFF_FFFF);
        rdreg(2, rd); chk("R1 count", rd, 32'hFFFF_FFFF);
        rdreg(3, rd); chk("R1 capture", rd, 32'h0);
        chk("R1 irqs", {30'd0, irq_underflow, irq_capture}, 32'h0);

        // R2 internal counting
        wr(2, 32'd10);
        wr(0, mk_ctrl(1, 0, 2'b00, 2'b00, 0));
        ticks(3);
        rdreg(2, rd); chk("R2 three ticks", rd, 32'd7);
        set_pin(1); set_pin(0);
        rdreg(2, rd); chk("R2 pin ignored", rd, 32'd7);

        // R9 write priority and reload write
        reg_wr = 1'b1; reg_addr = 2; reg_wdata = 32'd100; tick_en = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; tick_en = 1'b0;
        rdreg(2, rd); chk("R9 write beats tick", rd, 32'd100);
        wr(1, 32'h55);
        rdreg(2, rd); chk("R9 reload write keeps count", rd, 32'd100);

        // R4 underflow
        wr(1, 32'd4);
        wr(2, 32'd1);
        wr(0, mk_ctrl(1, 0, 2'b00, 2'b00, 1));
        ticks(2);
        rdreg(2, rd); chk("R4 wrap loads reload", rd, 32'd4);
        rdreg(0, rd); chk("R4 flag set", {31'd0, rd[8]}, 32'd1);
        chk("R4 irq_underflow", {31'd0, irq_underflow}, 32'd1);

        // R5 flag clear semantics
        wr(0, mk_ctrl(1, 0, 2'b00, 2'b00, 1));
        rdreg(0, rd); chk("R5 write 1 keeps flag", {31'd0, rd[8]}, 32'd1);
        wr(0, mk_ctrl(1, 0, 2'b00, 2'b00, 1) & ~32'h100);
        rdreg(0, rd); chk("R5 write 0 clears flag", {31'd0, rd[8]}, 32'd0);
        chk("R5 irq_underflow low", {31'd0, irq_underflow}, 32'd0);

        // R6 stopped: no counting, no capture
        wr(0, mk_ctrl(0, 0, 2'b00, 2'b01, 0));
        ticks(5);
        rdreg(2, rd); chk("R6 stopped count", rd, 32'd4);
        set_pin(1); set_pin(0);
        rdreg(3, rd); chk("R6 stopped capture", rd, 32'd0);

        // R3 external edges per select
        wr(2, 32'd50);
        wr(0, mk_ctrl(1, 1, 2'b00, 2'b00, 0));
        set_pin(1); set_pin(0); set_pin(1); set_pin(0);
        rdreg(2, rd); chk("R3 rising edges", rd, 32'd48);
        ticks(4);
        rdreg(2, rd); chk("R3 tick_en ignored", rd, 32'd48);
        wr(0, mk_ctrl(1, 1, 2'b01, 2'b00, 0));
        set_pin(1); set_pin(0); set_pin(1); set_pin(0);
        rdreg(2, rd); chk("R3 falling edges", rd, 32'd46);
        wr(0, mk_ctrl(1, 1, 2'b10, 2'b00, 0));
        set_pin(1); set_pin(0); set_pin(1); set_pin(0);
        rdreg(2, rd); chk("R3 both edges", rd, 32'd42);
        tmr_pin = 1'b1;
        repeat (2) @(negedge clk);
        rdreg(2, rd); chk("R3 not yet after two edges", rd, 32'd42);
        @(negedge clk);
        rdreg(2, rd); chk("R3 visible on third edge", rd, 32'd41);
        set_pin(0);

        // R8 pin source: capture mode on but no capture
        wr(0, mk_ctrl(1, 1, 2'b00, 2'b01, 0));
        set_pin(1); set_pin(0);
        rdreg(3, rd); chk("R8 no capture in pin mode", rd, 32'd0);

        // R7 capture on rising edge, no interrupt
        wr(2, 32'd200);
        wr(0, mk_ctrl(1, 0, 2'b00, 2'b01, 0));
        ticks(3);
        set_pin(1);
        rdreg(3, rd); chk("R7 rising capture", rd, 32'd197);
        rdreg(0, rd); chk("R7 capture flag", {31'd0, rd[9]}, 32'd1);
        chk("R7 no irq in mode 01", {31'd0, irq_capture}, 32'd0);
        set_pin(0);
        rdreg(3, rd); chk("R7 falling ignored in rise mode", rd, 32'd197);

        // R7 capture on falling edge with interrupt
        wr(0, mk_ctrl(1, 0, 2'b01, 2'b10, 0) & ~32'h200);
        ticks(7);
        set_pin(1);
        rdreg(3, rd); chk("R7 rising ignored in fall mode", rd, 32'd197);
        set_pin(0);
        rdreg(3, rd); chk("R7 falling capture", rd, 32'd190);
        chk("R7 irq_capture", {31'd0, irq_capture}, 32'd1);

        // R8 standby blocks capture
        standby = 1'b1;
        ticks(2);
        set_pin(1); set_pin(0);
        rdreg(3, rd); chk("R8 standby blocks", rd, 32'd190);
        standby = 1'b0;

        // R2/R4 random internal ticks
        exp_rel = 32'd7; exp_cnt = 32'd3; exp_uf = 0;
        wr(1, exp_rel);
        wr(2, exp_cnt);
        wr(0, mk_ctrl(1, 0, 2'b00, 2'b00, 1) & ~32'h300);
        void'($urandom(32'h1234));
        for (int i = 0; i < 400; i++) begin
            tick_en = $urandom % 2;
            @(negedge clk);
            if (tick_en) begin
                if (exp_cnt == 0) exp_uf = 1;
                exp_cnt = f_dec(exp_cnt, exp_rel);
            end
            if (i % 100 == 99) begin
                rdreg(2, rd); chk("R2 random internal count", rd, exp_cnt);
            end
        end
        tick_en = 1'b0;
        rdreg(0, rd); chk("R4 random flag", {31'd0, rd[8]}, {31'd0, exp_uf});

        // R3/R4 random external edges
        for (int blk = 0; blk < 3; blk++) begin
            logic [1:0] sel;
            sel = 2'($urandom % 4);
            exp_rel = 32'd9; exp_cnt = 32'($urandom % 12);
            wr(1, exp_rel);
            wr(2, exp_cnt);
            wr(0, mk_ctrl(1, 1, sel, 2'b00, 0));
            for (int i = 0; i < 40; i++) begin
                logic nv;
                nv = 1'($urandom % 2);
                if (f_counts(tmr_pin, nv, sel)) exp_cnt = f_dec(exp_cnt, exp_rel);
                set_pin(nv);
            end
            rdreg(2, rd); chk("R3 random external count", rd, exp_cnt);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule